// File: doc/BRIEF.md
# EEPROM Status Register and Write Guard

This unit keeps the control state of a serial EEPROM and decides, for every write the command engine wants to make, whether that write may go ahead. It holds a write-enable latch, a two-bit protection level, a lock-enable bit and shows the busy state of the self-timed write cycle. The protection level selects an address range near the top of the array that is read-only. The lock-enable bit works with an external active-low lock pin to freeze the status register itself.

The command engine decodes serial opcodes and gives this unit one-cycle strobes: set the write-enable latch, clear it, and request a status write with its data byte. The engine also drives the chip-select state and a busy level that covers each internal write cycle. In return the unit gives the status byte for a status read, a combinational grant for each array address the engine checks (several ports, so all bytes of a page can be checked before commit), and a grant for status writes. The unit does no serial shifting and holds no array. The protection bits are plain registers.

Top module: `sreg_protect_unit`

## Requirements
- R1: When `cycle_busy` is low, `status_byte` reads bit 7 = lock-enable, bits 6..4 = 0, bits 3..2 = protection level, bit 1 = write-enable latch, bit 0 = 0.
- R2: While `cycle_busy` is high, `status_byte` reads 0xFF.
- R3: After reset, the latch, the lock-enable bit and the protection level are all zero, so `status_byte` is 0x00.
- R4: A set strobe sets the latch only when `lock_n` is high. A clear strobe clears it whatever `lock_n` is.
- R5: The latch clears on the first clock edge where `cycle_busy` is seen low after being high. This happens at the end of every write cycle.
- R6: Level 00 protects no address. Level 01 protects addresses from 3/4 of the array upward (0x6000..0x7FFF for 15 bits). Level 10 protects the upper half (0x4000..0x7FFF). Level 11 protects every address. `arr_grant[i]` is high exactly when the latch is set and `chk_addr` slice i is not protected.
- R7: With the latch clear, `arr_grant` and `sr_grant` are all zero.
- R8: `sr_grant` is high when the latch is set, unless `lock_n` is low and lock-enable is 1. That lock does not remove grants for unprotected array addresses.
- R9: A granted status write request is held pending until the next cycle start. At the end of that cycle only bits 7, 3 and 2 of its data load into lock-enable and the level. Nothing in the readout changes before then.
- R10: A pending status write is dropped if `lock_n` is low while lock-enable is 1 and `sel_active` is high before the cycle starts. Once the cycle has started, `lock_n` no longer affects it.
- R11: While lock-enable is 1 and `lock_n` is low, a status write request is refused, and lock-enable stays 1 after a following cycle.
- R12: Set, clear and status write strobes that arrive while `cycle_busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lock_n | input | 1 | External lock pin, low requests hardware locking |
| sel_active | input | 1 | Chip select asserted (frame in progress) |
| cmd_wen_set | input | 1 | Strobe: set write-enable latch |
| cmd_wen_clr | input | 1 | Strobe: clear write-enable latch |
| sr_wr_req | input | 1 | Strobe: status write data byte received |
| sr_wr_data | input | 8 | Status write data byte |
| cycle_busy | input | 1 | Self-timed write cycle in progress |
| chk_addr | input | CHK_PORTS*ADDR_W | Array addresses to check, port i at slice i |
| status_byte | output | 8 | Byte returned by a status read |
| arr_grant | output | CHK_PORTS | Per-port array write grant |
| sr_grant | output | 1 | Status write grant |

## Verification
A latch or protection bit that holds the wrong value shows up in `status_byte` on the next idle read, and in the grant outputs in the same cycle, because both are combinational views of the stored state. A pending status write that is wrongly kept or wrongly dropped stays hidden until the following write cycle ends. So the bench checks the readout in the cycle right after `cycle_busy` falls, and again during busy, where the byte must be 0xFF. Region errors at the boundaries are found by placing one port on each side of every threshold.

// File: rtl/sreg_protect_pkg.sv
package sreg_protect_pkg;

   typedef enum logic [1:0] {
      PROT_NONE = 2'b00,
      PROT_QTR  = 2'b01,
      PROT_HALF = 2'b10,
      PROT_ALL  = 2'b11
   } prot_lvl_t;

   // bit positions inside the status byte
   localparam int SB_BUSY  = 0;
   localparam int SB_WEL   = 1;
   localparam int SB_LVL_L = 2;
   localparam int SB_LVL_H = 3;
   localparam int SB_LOCK  = 7;

   typedef struct packed {
      logic      lock_en;
      prot_lvl_t lvl;
   } nv_bits_t;

endpackage

// File: rtl/sreg_region_chk.sv
module sreg_region_chk
   import sreg_protect_pkg::*;
#(
   parameter int ADDR_W = 15
) (
   input  logic [ADDR_W-1:0] addr,
   input  prot_lvl_t         lvl,
   input  logic              wel,
   output logic              grant
);
   localparam logic [ADDR_W-1:0] QTR_BOUND  = ADDR_W'(3) << (ADDR_W - 2);
   localparam logic [ADDR_W-1:0] HALF_BOUND = ADDR_W'(1) << (ADDR_W - 1);

   logic locked;

   always_comb begin
      unique case (lvl)
         PROT_NONE: locked = 1'b0;
         PROT_QTR:  locked = (addr >= QTR_BOUND);
         PROT_HALF: locked = (addr >= HALF_BOUND);
         default:   locked = 1'b1;
      endcase
   end

   assign grant = wel & ~locked;

endmodule

// File: rtl/sreg_wel.sv
module sreg_wel (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_set,
   input  logic cmd_clr,
   input  logic lock_n,
   input  logic busy,
   input  logic cyc_done,
   output logic wel
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel <= 1'b0;
      end else if (cyc_done) begin
         wel <= 1'b0;
      end else if (!busy) begin
         if (cmd_clr)
            wel <= 1'b0;
         else if (cmd_set && lock_n)
            wel <= 1'b1;
      end
   end

   // latch rises only after a set strobe seen with the pin high
   assert_wel_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel) |-> ($past(lock_n) && $past(cmd_set)));

   // end of any write cycle leaves the latch clear
   assert_wel_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_done |=> !wel);

endmodule

// File: rtl/sreg_nvbits.sv
module sreg_nvbits
   import sreg_protect_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel,
   input  logic       lock_n,
   input  logic       busy,
   input  logic       cyc_start,
   input  logic       cyc_done,
   input  logic       wr_req,
   input  logic [7:0] wr_data,
   input  logic       wr_grant,
   output nv_bits_t   nv
);
   nv_bits_t pend;
   logic     pend_valid;
   logic     armed;
   logic     sel_q;
   logic     sel_rise;
   logic     hw_lock;
   logic     commit;
   wire      unused_data = ^{wr_data[6:4], wr_data[SB_WEL], wr_data[SB_BUSY]};

   assign sel_rise = sel & ~sel_q;
   assign hw_lock  = ~lock_n & nv.lock_en;
   assign commit   = cyc_done & armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= 1'b0;
      else        sel_q <= sel;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_valid <= 1'b0;
         pend       <= '0;
         armed      <= 1'b0;
      end else if (cyc_start) begin
         armed      <= pend_valid;
         pend_valid <= 1'b0;
      end else if (commit) begin
         armed <= 1'b0;
      end else if (!busy) begin
         if (wr_req && wr_grant) begin
            pend_valid   <= 1'b1;
            pend.lock_en <= wr_data[SB_LOCK];
            pend.lvl     <= prot_lvl_t'(wr_data[SB_LVL_H:SB_LVL_L]);
         end else if (sel_rise) begin
            pend_valid <= 1'b0;
         end else if (pend_valid && sel && hw_lock) begin
            pend_valid <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      nv <= '0;
      else if (commit) nv <= pend;
   end

   // stored bits move only at the end of an armed cycle
   assert_bits_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(nv));

   // lock during an open frame drops a pending status write
   assert_cancel_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_valid && sel && !lock_n && nv.lock_en && !busy && !cyc_start)
      |=> !pend_valid);

endmodule

// File: rtl/sreg_protect_unit.sv
module sreg_protect_unit
   import sreg_protect_pkg::*;
#(
   parameter int ADDR_W    = 15,
   parameter int CHK_PORTS = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        lock_n,
   input  logic                        sel_active,
   input  logic                        cmd_wen_set,
   input  logic                        cmd_wen_clr,
   input  logic                        sr_wr_req,
   input  logic [7:0]                  sr_wr_data,
   input  logic                        cycle_busy,
   input  logic [CHK_PORTS*ADDR_W-1:0] chk_addr,
   output logic [7:0]                  status_byte,
   output logic [CHK_PORTS-1:0]        arr_grant,
   output logic                        sr_grant
);
   localparam int ADDR_BUS_W = CHK_PORTS * ADDR_W;

   generate
      if (ADDR_W < 2) begin : g_bad_aw
         $error("ADDR_W must be at least 2");
      end
      if (CHK_PORTS < 1) begin : g_bad_ports
         $error("CHK_PORTS must be at least 1");
      end
      if (ADDR_BUS_W != $bits(chk_addr)) begin : g_bad_bus
         $error("address bus width mismatch");
      end
   endgenerate

   logic     busy_q;
   logic     cyc_start;
   logic     cyc_done;
   logic     wel;
   nv_bits_t nv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_q <= 1'b0;
      else        busy_q <= cycle_busy;
   end

   assign cyc_start = cycle_busy & ~busy_q;
   assign cyc_done  = ~cycle_busy & busy_q;

   sreg_wel u_wel (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_set  (cmd_wen_set),
      .cmd_clr  (cmd_wen_clr),
      .lock_n   (lock_n),
      .busy     (cycle_busy),
      .cyc_done (cyc_done),
      .wel      (wel)
   );

   assign sr_grant = wel & ~(~lock_n & nv.lock_en);

   sreg_nvbits u_nv (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel_active),
      .lock_n    (lock_n),
      .busy      (cycle_busy),
      .cyc_start (cyc_start),
      .cyc_done  (cyc_done),
      .wr_req    (sr_wr_req),
      .wr_data   (sr_wr_data),
      .wr_grant  (sr_grant),
      .nv        (nv)
   );

   generate
      for (genvar i = 0; i < CHK_PORTS; i++) begin : g_port
         sreg_region_chk #(.ADDR_W(ADDR_W)) u_chk (
            .addr  (chk_addr[i*ADDR_W +: ADDR_W]),
            .lvl   (nv.lvl),
            .wel   (wel),
            .grant (arr_grant[i])
         );
      end
   endgenerate

   always_comb begin
      if (cycle_busy) begin
         status_byte = 8'hFF;
      end else begin
         status_byte                    = 8'h00;
         status_byte[SB_LOCK]           = nv.lock_en;
         status_byte[SB_LVL_H:SB_LVL_L] = nv.lvl;
         status_byte[SB_WEL]            = wel;
      end
   end

   // no grant of either kind without the latch
   assert_grant_wel_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|arr_grant || sr_grant) |-> wel);

endmodule

// File: tb/sreg_protect_unit_test.sv
`timescale 1ns/1ps
module sreg_protect_unit_test;
   localparam int AW = 15;
   localparam int NP = 2;

   logic clk = 0;
   logic rst_n = 0;
   logic lock_n = 1, sel_active = 0, cmd_wen_set = 0, cmd_wen_clr = 0;
   logic sr_wr_req = 0, cycle_busy = 0;
   logic [7:0] sr_wr_data = 0;
   logic [NP*AW-1:0] chk_addr = '0;
   logic [7:0] status_byte;
   logic [NP-1:0] arr_grant;
   logic sr_grant;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   sreg_protect_unit #(.ADDR_W(AW), .CHK_PORTS(NP)) uut (
      .clk(clk), .rst_n(rst_n), .lock_n(lock_n), .sel_active(sel_active),
      .cmd_wen_set(cmd_wen_set), .cmd_wen_clr(cmd_wen_clr),
      .sr_wr_req(sr_wr_req), .sr_wr_data(sr_wr_data),
      .cycle_busy(cycle_busy), .chk_addr(chk_addr),
      .status_byte(status_byte), .arr_grant(arr_grant), .sr_grant(sr_grant));

   typedef struct {
      int         kind;
      logic [7:0] exp;
      string      tag;
   } item_t;
   item_t q[$];

   task automatic push(int k, logic [7:0] v, string t);
      item_t it;
      it.kind = k; it.exp = v; it.tag = t;
      q.push_back(it);
   endtask
   task automatic exp_status(logic [7:0] v, string t); push(0, v, t); endtask
   task automatic exp_arr(logic [1:0] v, string t);    push(1, {6'b0, v}, t); endtask
   task automatic exp_srg(logic v, string t);          push(2, {7'b0, v}, t); endtask

   // monitor: compares queued expectations away from the active edge
   initial begin
      forever begin
         @(negedge clk);
         while (q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = q.pop_front();
            case (it.kind)
               0:       act = status_byte;
               1:       act = {6'b0, arr_grant};
               default: act = {7'b0, sr_grant};
            endcase
            checks++;
            if (act !== it.exp) begin
               failures++;
               $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
            end
         end
      end
   end

   task automatic step(); @(posedge clk); #2; endtask
   task automatic wen();  step(); cmd_wen_set = 1; step(); cmd_wen_set = 0; endtask
   task automatic wdis(); step(); cmd_wen_clr = 1; step(); cmd_wen_clr = 0; endtask
   task automatic srw(logic [7:0] d);
      step(); sel_active = 1; sr_wr_req = 1; sr_wr_data = d;
      step(); sr_wr_req = 0;
   endtask
   task automatic frame_end_busy(); step(); sel_active = 0; cycle_busy = 1; endtask
   task automatic busy_end(); step(); cycle_busy = 0; step(); endtask
   task automatic set_addr(logic [AW-1:0] a0, logic [AW-1:0] a1); chk_addr = {a1, a0}; endtask

   initial begin
      #(8 * 50000);
      if (!finished) begin
         failures++;
         $display("FAIL R12 watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      set_addr(15'h0000, 15'h7FFF);
      exp_status(8'h00, "R3 reset status");
      exp_srg(1'b0, "R7 reset sr_grant");
      exp_arr(2'b00, "R7 reset arr_grant");

      // latch set with pin high
      wen();
      exp_status(8'h02, "R4 R1 latch set");
      exp_srg(1'b1, "R8 sr_grant open");
      exp_arr(2'b11, "R6 level 00 all writable");
      wdis();
      exp_status(8'h00, "R4 latch cleared");
      exp_arr(2'b00, "R7 no grant without latch");

      // set refused with pin low, clear works with pin low
      step(); lock_n = 0;
      wen();
      exp_status(8'h00, "R4 set refused pin low");
      step(); lock_n = 1;
      wen();
      step(); lock_n = 0;
      wdis();
      exp_status(8'h00, "R4 clear with pin low");

      // status write, junk in unused bits
      step(); lock_n = 1;
      wen();
      srw(8'h77);
      exp_status(8'h02, "R9 pending not visible");
      frame_end_busy();
      exp_status(8'hFF, "R2 busy reads ones");
      busy_end();
      exp_status(8'h04, "R9 R5 commit level 01");

      wen();
      set_addr(15'h5FFF, 15'h6000);
      exp_arr(2'b01, "R6 quarter boundary");
      exp_status(8'h06, "R1 level 01 latch set");
      srw(8'h08); frame_end_busy(); busy_end();
      wen();
      set_addr(15'h3FFF, 15'h4000);
      exp_arr(2'b01, "R6 half boundary");
      exp_status(8'h0A, "R1 level 10");
      srw(8'h0C); frame_end_busy(); busy_end();
      wen();
      set_addr(15'h0000, 15'h2000);
      exp_arr(2'b00, "R6 all protected");
      exp_status(8'h0E, "R1 level 11");

      // lock-enable set, then hardware lock
      srw(8'h80); frame_end_busy(); busy_end();
      exp_status(8'h80, "R9 lock bit committed");
      wen();
      exp_srg(1'b1, "R8 sr_grant pin high");
      step(); lock_n = 0;
      set_addr(15'h0000, 15'h7FFF);
      exp_srg(1'b0, "R8 sr_grant locked");
      exp_arr(2'b11, "R8 array still writable");
      exp_status(8'h82, "R1 lock and latch");

      // sticky lock-enable
      srw(8'h00); frame_end_busy(); busy_end();
      exp_status(8'h80, "R11 lock bit sticky");

      // cancel before cycle start
      step(); lock_n = 1;
      wen();
      srw(8'h0C);
      step(); lock_n = 0;
      frame_end_busy(); busy_end();
      exp_status(8'h80, "R10 pending dropped");

      // lock after cycle start has no effect
      step(); lock_n = 1;
      wen();
      srw(8'h04);
      frame_end_busy();
      step(); lock_n = 0;
      busy_end();
      exp_status(8'h04, "R10 started write kept");

      // strobes ignored while busy
      step(); lock_n = 1; cycle_busy = 1;
      wen();
      exp_srg(1'b0, "R12 set ignored busy");
      exp_status(8'hFF, "R2 busy ones again");
      busy_end();
      exp_status(8'h04, "R12 after busy");
      wen();
      exp_srg(1'b1, "R4 latch set again");
      step(); cycle_busy = 1;
      wdis();
      exp_srg(1'b1, "R12 clear ignored busy");
      busy_end();
      exp_status(8'h04, "R5 latch clear at done");
      exp_srg(1'b0, "R5 no sr_grant after done");

      step(); step();
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule